// File: doc/BRIEF.md
# Folded Multi-Pass Local Alignment Scorer

This block computes the best local-alignment score (linear gap, zero floor) between a query and a subject sequence. It uses a fixed chain of `P` scoring elements that is shorter than the longest query. The query is split into consecutive slices of `P` positions. The subject residues stream through the chain once per slice.

Between passes, a feedback buffer captures the score column and the residue that leave the last element. It returns them to the chain input on the next pass. Each element keeps one substitution-score column per pass, and the pass index picks that bank. The subject is accepted once, over a valid/ready stream, during the first pass; later passes replay it from the buffer. The block keeps the maximum over every cell of every pass and reports it with a one-cycle done pulse.

Score tables are loaded beforehand through a serial shift chain while the configuration bit is high. A job starts with a start pulse once the bit is low. Query length and subject length are plain inputs that are sampled at start.

Top module: `fold_align_top`

## Requirements
- R1: While `cfg_mode`=1 and the block is idle, each cycle with `cfg_valid`=1 shifts `cfg_word` into a serial chain of `P*NPASS*2^SYM_W` signed words.
  - After a full load, the word shifted in first sits at the highest chain position. Position `g` decodes as element `g / (NPASS*2^SYM_W)`, then bank `(g mod (NPASS*2^SYM_W)) / 2^SYM_W`, then subject symbol `g mod 2^SYM_W`.
  - Element `e` with bank `b` serves query position `b*P+e`.
- R2: `start` is ignored while `cfg_mode`=1. No job begins and `s_ready` stays 0.
- R3: For a query of length `qlen` ≤ `P` (one pass), `best` equals the maximum over all cells of `H(i,j) = max(0, H(i-1,j-1)+S(i,s_j), H(i-1,j)-gap, H(i,j-1)-gap)`, with zero borders. Here `S(i,s)` is the loaded word for query position `i` and subject symbol `s`.
- R4: A query longer than `P` runs in `ceil(qlen/P)` passes. Pass `p` uses bank `p`. The first pass has zero as its left edge; later passes take the buffered last-element column, and the final pass writes nothing to the buffer. `best` equals the full-matrix maximum of R3.
- R5: On the last pass, elements whose query position is `qlen` or more pass the incoming score through unchanged. The result equals the R3 maximum for exactly `qlen` positions.
- R6: Subject stream back-pressure rules:
  - `s_ready` is 1 only during the first pass while fewer than `slen` residues have been accepted. A residue is taken on a cycle with `s_valid` and `s_ready` both 1.
  - Idle cycles with `s_valid`=0 do not change the result.
  - `s_ready` is 0 in all later passes and when idle.
- R7: `done` is a single-cycle pulse after the last residue leaves the final pass. `best` is final in that cycle and holds until the next accepted start.
- R8: After reset, `done`=0, `s_ready`=0 and `best`=0.
- R9: Cell scores never go below zero. A job in which every score word used is negative reports `best`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_mode | input | 1 | 1 = table loading, start blocked |
| cfg_valid | input | 1 | Shift one table word this cycle |
| cfg_word | input | TW | Signed score word entering the chain |
| gap | input | GAP_W | Linear gap penalty, sampled every cycle, hold during a job |
| qlen | input | QL_W | Query length, 1 to P*NPASS, sampled at start |
| slen | input | SL_W | Subject length, 1 to MAX_SUBJ, sampled at start |
| start | input | 1 | Begin a job when idle and cfg_mode=0 |
| s_valid | input | 1 | Subject residue valid |
| s_ready | output | 1 | Subject residue accepted when high with s_valid |
| s_sym | input | SYM_W | Subject residue code |
| best | output | SCORE_W | Best local score of the last job |
| done | output | 1 | One-cycle end-of-job pulse |

## Verification
The bench targets query lengths that are exact multiples of the chain length, lengths that leave elements idle on the last pass, and single-residue jobs.

- If the design fed stale or zero boundary scores into a later pass, or picked the wrong bank, it would report a lower best score on multi-pass vectors.
- If it kept idle elements scoring, it would credit query positions that do not exist.
- Gapped subject streams check that bubbles do not advance element state. A design that let bubbles advance the state would shift the diagonal and change the score.
- A start raised during configuration must not launch a job.
- The done pulse must be one cycle wide, with the score held afterwards.

// File: rtl/fold_pkg.sv
package fold_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} fold_state_e;

  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction
endpackage

// File: rtl/fold_pe.sv
module fold_pe #(
  parameter int NPASS   = 3,
  parameter int SYM_W   = 2,
  parameter int TW      = 5,
  parameter int SCORE_W = 10,
  parameter int GAP_W   = 4,
  parameter int PS_W    = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_shift,
  input  logic [TW-1:0]      cfg_in,
  output logic [TW-1:0]      cfg_out,
  input  logic [PS_W-1:0]    bank,
  input  logic               enable,
  input  logic               clr,
  input  logic [GAP_W-1:0]   gap,
  input  logic               in_v,
  input  logic [SYM_W-1:0]   in_sym,
  input  logic [SCORE_W-1:0] in_h,
  output logic               out_v,
  output logic [SYM_W-1:0]   out_sym,
  output logic [SCORE_W-1:0] out_h
);
  localparam int ALPH  = 1 << SYM_W;
  localparam int LOC   = NPASS * ALPH;
  localparam int IDX_W = $clog2(LOC);
  localparam int EW    = SCORE_W + 2;

  logic signed [TW-1:0] tbl [LOC];
  logic [SCORE_W-1:0]   h_prev, left_prev, h_new;
  logic [IDX_W-1:0]     idx;
  logic signed [EW-1:0] diag, up, lf, m, gap_e, sub_e;

  // serial table chain, one word per shift
  always_ff @(posedge clk) begin
    if (cfg_shift) begin
      tbl[0] <= cfg_in;
      for (int i = 1; i < LOC; i++) tbl[i] <= tbl[i-1];
    end
  end
  assign cfg_out = tbl[LOC-1];

  assign idx = IDX_W'(int'(bank) * ALPH + int'(in_sym));

  always_comb begin
    sub_e = EW'(tbl[idx]);
    gap_e = $signed({{(EW-GAP_W){1'b0}}, gap});
    diag  = $signed({2'b00, left_prev}) + sub_e;
    up    = $signed({2'b00, in_h}) - gap_e;
    lf    = $signed({2'b00, h_prev}) - gap_e;
    m     = diag;
    if (up > m) m = up;
    if (lf > m) m = lf;
    if (m[EW-1])      h_new = '0;
    else if (m[EW-2]) h_new = '1;
    else              h_new = m[SCORE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_v <= 1'b0; out_sym <= '0; out_h <= '0;
      h_prev <= '0; left_prev <= '0;
    end else if (clr) begin
      out_v <= 1'b0; out_h <= '0;
      h_prev <= '0; left_prev <= '0;
    end else if (in_v) begin
      out_v   <= 1'b1;
      out_sym <= in_sym;
      if (enable) begin
        out_h     <= h_new;
        h_prev    <= h_new;
        left_prev <= in_h;
      end else begin
        out_h <= in_h;
      end
    end else begin
      out_v <= 1'b0;
    end
  end

  // R5
  pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_v && !enable && !clr) |=> (out_h == $past(in_h)));

  // R6
  bubble_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_v && !clr) |=> $stable(h_prev) && $stable(left_prev));
endmodule

// File: rtl/fold_fbuf.sv
module fold_fbuf #(
  parameter int DEPTH = 16,
  parameter int W     = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_idx,
  input  logic [W-1:0]             wr_data,
  input  logic                     rd_en,
  input  logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic [W-1:0]             rd_data
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end
  assign rd_data = mem[rd_idx];

  // R4: a slot is always read for this pass before it is overwritten
  slot_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && wr_en) |-> (wr_idx < rd_idx));
endmodule

// File: rtl/fold_maxsel.sv
module fold_maxsel #(
  parameter int N = 4,
  parameter int W = 10
) (
  input  logic [N-1:0]   v,
  input  logic [N*W-1:0] h,
  output logic [W-1:0]   m
);
  always_comb begin
    m = '0;
    for (int k = 0; k < N; k++)
      if (v[k] && (h[k*W +: W] > m)) m = h[k*W +: W];
  end
endmodule

// File: rtl/fold_align_top.sv
module fold_align_top
  import fold_pkg::*;
#(
  parameter int P        = 4,
  parameter int NPASS    = 3,
  parameter int SYM_W    = 2,
  parameter int TW       = 5,
  parameter int SCORE_W  = 10,
  parameter int GAP_W    = 4,
  parameter int MAX_SUBJ = 16,
  localparam int QL_W    = $clog2(P*NPASS + 1),
  localparam int SL_W    = $clog2(MAX_SUBJ + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_mode,
  input  logic               cfg_valid,
  input  logic [TW-1:0]      cfg_word,
  input  logic [GAP_W-1:0]   gap,
  input  logic [QL_W-1:0]    qlen,
  input  logic [SL_W-1:0]    slen,
  input  logic               start,
  input  logic               s_valid,
  output logic               s_ready,
  input  logic [SYM_W-1:0]   s_sym,
  output logic [SCORE_W-1:0] best,
  output logic               done
);
  localparam int PS_W = (NPASS > 1) ? $clog2(NPASS) : 1;
  localparam int IX_W = $clog2(MAX_SUBJ);
  localparam int FB_W = SYM_W + SCORE_W;

  fold_state_e        state_q;
  logic [PS_W-1:0]    pass_q, lastp_q;
  logic [QL_W-1:0]    qlen_q;
  logic [SL_W-1:0]    slen_q, feed_cnt, out_cnt;
  logic [SCORE_W-1:0] best_q, cyc_max;
  logic               done_q;

  logic [P:0]         ch_v;
  logic [SYM_W-1:0]   ch_sym [P+1];
  logic [SCORE_W-1:0] ch_h   [P+1];
  logic [TW-1:0]      cfg_ch [P+1];
  logic [P-1:0]       pe_en;
  logic [P*SCORE_W-1:0] h_flat;

  logic go, first_pass, is_last, feeding, last_out, pe_clr, cfg_shift;
  logic fb_wr, fb_rd;
  logic [FB_W-1:0] fb_q;

  assign go         = (state_q == ST_IDLE) && start && !cfg_mode;
  assign cfg_shift  = (state_q == ST_IDLE) && cfg_mode && cfg_valid;
  assign first_pass = (pass_q == '0);
  assign is_last    = (pass_q == lastp_q);
  assign feeding    = (state_q == ST_RUN) && (feed_cnt < slen_q);
  assign s_ready    = feeding && first_pass;
  assign last_out   = (state_q == ST_RUN) && ch_v[P] && (out_cnt == slen_q - SL_W'(1));
  assign pe_clr     = go || (last_out && !is_last);

  // chain input: subject stream on the first pass, replay buffer later
  assign ch_v[0]   = feeding && (first_pass ? s_valid : 1'b1);
  assign ch_sym[0] = first_pass ? s_sym : fb_q[FB_W-1 -: SYM_W];
  assign ch_h[0]   = first_pass ? '0 : fb_q[SCORE_W-1:0];
  assign cfg_ch[0] = cfg_word;

  generate
    for (genvar k = 0; k < P; k++) begin : g_pe
      assign pe_en[k] = (int'(pass_q) * P + k) < int'(qlen_q);
      fold_pe #(
        .NPASS(NPASS), .SYM_W(SYM_W), .TW(TW),
        .SCORE_W(SCORE_W), .GAP_W(GAP_W), .PS_W(PS_W)
      ) u_pe (
        .clk(clk), .rst_n(rst_n),
        .cfg_shift(cfg_shift), .cfg_in(cfg_ch[k]), .cfg_out(cfg_ch[k+1]),
        .bank(pass_q), .enable(pe_en[k]), .clr(pe_clr), .gap(gap),
        .in_v(ch_v[k]), .in_sym(ch_sym[k]), .in_h(ch_h[k]),
        .out_v(ch_v[k+1]), .out_sym(ch_sym[k+1]), .out_h(ch_h[k+1])
      );
      assign h_flat[k*SCORE_W +: SCORE_W] = ch_h[k+1];
    end
  endgenerate

  fold_maxsel #(.N(P), .W(SCORE_W)) u_max (
    .v(ch_v[P:1]), .h(h_flat), .m(cyc_max)
  );

  assign fb_wr = (state_q == ST_RUN) && ch_v[P] && !is_last;
  assign fb_rd = feeding && !first_pass;

  fold_fbuf #(.DEPTH(MAX_SUBJ), .W(FB_W)) u_fb (
    .clk(clk), .rst_n(rst_n),
    .wr_en(fb_wr), .wr_idx(out_cnt[IX_W-1:0]), .wr_data({ch_sym[P], ch_h[P]}),
    .rd_en(fb_rd), .rd_idx(feed_cnt[IX_W-1:0]), .rd_data(fb_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; pass_q <= '0; lastp_q <= '0;
      qlen_q <= '0; slen_q <= '0; feed_cnt <= '0; out_cnt <= '0;
      best_q <= '0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go) begin
        state_q  <= ST_RUN;
        pass_q   <= '0;
        lastp_q  <= PS_W'(ceil_div(int'(qlen), P) - 1);
        qlen_q   <= qlen;
        slen_q   <= slen;
        feed_cnt <= '0;
        out_cnt  <= '0;
        best_q   <= '0;
      end else if (state_q == ST_RUN) begin
        if (ch_v[0]) feed_cnt <= feed_cnt + SL_W'(1);
        if (ch_v[P]) out_cnt  <= out_cnt + SL_W'(1);
        if (cyc_max > best_q) best_q <= cyc_max;
        if (last_out) begin
          feed_cnt <= '0;
          out_cnt  <= '0;
          if (is_last) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            pass_q <= pass_q + PS_W'(1);
          end
        end
      end
    end
  end

  assign best = best_q;
  assign done = done_q;

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  best_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_IDLE) && !go) |=> $stable(best));

  // R2
  cfg_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_IDLE) && cfg_mode) |=> (state_q == ST_IDLE));

  // R4
  pass_lim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |-> (pass_q <= lastp_q));

  // R6
  feed_lim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |-> (feed_cnt <= slen_q));
endmodule

// File: tb/sim_fold_align_top.sv
module sim_fold_align_top;
  localparam int CLK_P    = 10;
  localparam int P        = 4;
  localparam int NPASS    = 3;
  localparam int SYM_W    = 2;
  localparam int TW       = 5;
  localparam int SCORE_W  = 10;
  localparam int GAP_W    = 4;
  localparam int MAX_SUBJ = 16;
  localparam int QL_W     = $clog2(P*NPASS + 1);
  localparam int SL_W     = $clog2(MAX_SUBJ + 1);
  localparam int ALPH     = 1 << SYM_W;
  localparam int LOC      = NPASS * ALPH;
  localparam int MATCH    = 5;
  localparam int MISM     = -3;

  typedef struct packed {
    int          ql;
    int          sl;
    int          g;
    logic [23:0] q;
    logic [31:0] s;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{ql: 4,  sl: 8,  g: 2, q: 24'h00001B, s: 32'h00006C1B},
    '{ql: 12, sl: 16, g: 2, q: 24'hE41B93, s: 32'h1B93E46C},
    '{ql: 6,  sl: 5,  g: 3, q: 24'h0009C6, s: 32'h000002D8},
    '{ql: 1,  sl: 1,  g: 1, q: 24'h000000, s: 32'h00000000},
    '{ql: 9,  sl: 16, g: 1, q: 24'h01E427, s: 32'hE4E42727},
    '{ql: 7,  sl: 6,  g: 2, q: 24'h000000, s: 32'h00000555}
  };

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               cfg_mode = 1'b0, cfg_valid = 1'b0;
  logic [TW-1:0]      cfg_word = '0;
  logic [GAP_W-1:0]   gap = '0;
  logic [QL_W-1:0]    qlen = '0;
  logic [SL_W-1:0]    slen = '0;
  logic               start = 1'b0, s_valid = 1'b0;
  logic [SYM_W-1:0]   s_sym = '0;
  logic               s_ready, done;
  logic [SCORE_W-1:0] best;

  int errs = 0;
  int checks = 0;

  always #(CLK_P/2) clk = ~clk;

  fold_align_top #(
    .P(P), .NPASS(NPASS), .SYM_W(SYM_W), .TW(TW),
    .SCORE_W(SCORE_W), .GAP_W(GAP_W), .MAX_SUBJ(MAX_SUBJ)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_valid(cfg_valid),
    .cfg_word(cfg_word), .gap(gap), .qlen(qlen), .slen(slen), .start(start),
    .s_valid(s_valid), .s_ready(s_ready), .s_sym(s_sym), .best(best), .done(done)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // independent full-matrix model
  function automatic int ref_best(input vec_t v);
    int h [0:12][0:16];
    int mx = 0;
    for (int i = 0; i <= 12; i++)
      for (int j = 0; j <= 16; j++) h[i][j] = 0;
    for (int i = 1; i <= v.ql; i++)
      for (int j = 1; j <= v.sl; j++) begin
        int sc = (v.q[2*(i-1) +: 2] == v.s[2*(j-1) +: 2]) ? MATCH : MISM;
        int c = h[i-1][j-1] + sc;
        if (h[i-1][j] - v.g > c) c = h[i-1][j] - v.g;
        if (h[i][j-1] - v.g > c) c = h[i][j-1] - v.g;
        if (c < 0) c = 0;
        h[i][j] = c;
        if (c > mx) mx = c;
      end
    return mx;
  endfunction

  // R1: first word in lands at the highest chain position
  task automatic load_tables(input logic [23:0] qs);
    @(negedge clk);
    cfg_mode = 1'b1;
    for (int g = P*LOC - 1; g >= 0; g--) begin
      int pe = g / LOC;
      int bk = (g % LOC) / ALPH;
      int sy = g % ALPH;
      int qp = bk * P + pe;
      cfg_valid = 1'b1;
      cfg_word  = (qs[2*qp +: 2] == 2'(sy)) ? TW'(MATCH) : TW'(MISM);
      @(negedge clk);
    end
    cfg_valid = 1'b0;
    cfg_mode  = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_job(input vec_t v, input bit gapped, output int got);
    int idx = 0;
    int cyc = 0;
    int wait_n = 0;
    gap  = GAP_W'(v.g);
    qlen = QL_W'(v.ql);
    slen = SL_W'(v.sl);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (idx < v.sl) begin
      s_valid = gapped ? (cyc % 2 == 0) : 1'b1;
      s_sym   = v.s[2*idx +: 2];
      if (s_valid && s_ready) idx++;
      @(negedge clk);
      cyc++;
    end
    s_valid = 1'b0;
    // R6: no more residues taken once slen accepted
    check(s_ready == 1'b0, "R6 ready low after subject", int'(s_ready), 0);
    while (!done && wait_n < 500) begin
      @(negedge clk);
      wait_n++;
    end
    check(done == 1'b1, "R7 done seen", int'(done), 1);
    got = int'(best);
    @(negedge clk);
    check(done == 1'b0, "R7 done single cycle", int'(done), 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int got;
    int exp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8
    check(done == 1'b0, "R8 done after reset", int'(done), 0);
    check(s_ready == 1'b0, "R8 s_ready after reset", int'(s_ready), 0);
    check(best == '0, "R8 best after reset", int'(best), 0);

    // R2: start during configuration is dropped
    cfg_mode = 1'b1;
    start = 1'b1;
    qlen = QL_W'(4);
    slen = SL_W'(4);
    @(negedge clk);
    start = 1'b0;
    check(s_ready == 1'b0, "R2 no job while cfg", int'(s_ready), 0);
    cfg_mode = 1'b0;
    repeat (2) @(negedge clk);
    check(s_ready == 1'b0, "R2 no job after cfg", int'(s_ready), 0);

    // vector table: R1 R3 R4 R5 R9
    for (int n = 0; n < NV; n++) begin
      load_tables(VECS[n].q);
      run_job(VECS[n], 1'b0, got);
      exp = ref_best(VECS[n]);
      check(got == exp, "R1/R3/R4/R5 vector score", got, exp);
      @(negedge clk);
    end

    // R9: all-mismatch vector floors at zero
    check(ref_best(VECS[5]) == 0 && best == '0, "R9 floor zero", int'(best), 0);

    // R6: bubbly stream, three passes, same answer
    load_tables(VECS[1].q);
    run_job(VECS[1], 1'b1, got);
    exp = ref_best(VECS[1]);
    check(got == exp, "R6 gapped stream score", got, exp);

    // R7: best holds while idle
    repeat (4) @(negedge clk);
    check(int'(best) == exp, "R7 best held", int'(best), exp);

    // R5: partial last pass with bubbles
    load_tables(VECS[4].q);
    run_job(VECS[4], 1'b1, got);
    exp = ref_best(VECS[4]);
    check(got == exp, "R5 partial pass gapped", got, exp);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule